// File: doc/BRIEF.md
# Universal Synchronous Shift Interface

This peripheral gives a small processor the hardware core of a serial link while leaving protocol decisions to software. One 8-bit shift register carries data in both directions. Each sample edge of the serial clock moves it one place toward the MSB and takes the incoming line into the LSB. The MSB reaches the output pin through a latch that only follows the register while the clock sits in the phase before a sample edge. A 4-bit edge counter marks the end of each byte. When it wraps, the finished byte is copied into a buffer register and an overflow flag is raised.

The block runs as a three-wire link (separate data in, data out and clock pins) or as a two-wire link. In two-wire mode the data and clock lines are open-drain and a start-condition detector is active. The serial clock comes from the external clock pin, from a timer compare-match pulse, or from a software strobe. With the two internal sources the block generates the clock itself and acts as master. In two-wire mode the block stretches the clock line low while either flag is pending, which holds the remote master until software has handled the event. All external pins pass through synchronizers into the system clock domain. Software uses a four-register bus: data, buffer, status and control.

Top module: `ussi_top`

## Requirements
- R1: After reset, all four registers read 0x00, do_o, sck_o, irq_start, irq_ovf, sda_drive_low and scl_drive_low are all 0, and the output latch holds 1.
- R2: On each sample edge the data register shifts toward the MSB and takes the data input (di_i in three-wire, the SDA line in two-wire) into bit 0. Control bit 4 = 0 makes rising edges the sample edges; control bit 4 = 1 makes falling edges the sample edges.
- R3: The output latch follows data register bit 7 only while the serial clock is in the phase before a sample edge, and holds its value otherwise. In three-wire mode do_o carries the latch value. In two-wire mode sda_drive_low is 1 exactly when the latch holds 0.
- R4: The counter (status bits 3:0) advances on every serial clock edge. On 15 to 0 it sets the overflow flag (status bit 6).
- R5: On overflow the buffer register (address 1) takes the data register value that includes that edge's shift. At all other times the buffer keeps its value.
- R6: Control bits 3:2 select the clock source: 00 is the clock pin (sck_i in three-wire, the SCL line in two-wire), 01 is a tmr_match pulse, and 10 is writing control with bit 5 set. Each internal event toggles an internal clock that starts low and drives sck_o in three-wire mode.
- R7: In two-wire mode only, the SDA line falling while SCL is high sets the start flag (status bit 7) and clears the counter. While the start flag is set, clock edges neither count nor shift.
- R8: In two-wire mode scl_drive_low is 1 while the start flag or the overflow flag is set. Clock edges from the remote side cannot reach the block while the line is held.
- R9: Writing status with bit 7 or bit 6 set clears that flag, and writing 0 to a flag bit leaves it unchanged. Each status write also loads bits 3:0 into the counter.
- R10: irq_start equals start flag AND control bit 6, and irq_ovf equals overflow flag AND control bit 7.
- R11: Control bits 1:0 select the mode: 01 is three-wire, 10 is two-wire, 00 is off. In off mode clock edges are ignored and do_o, sck_o, sda_drive_low and scl_drive_low stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 data, 1 buffer, 2 status, 3 control |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for bus_addr |
| tmr_match | input | 1 | Timer compare-match pulse, used as a clock source |
| sck_i | input | 1 | Three-wire clock pin input |
| sck_o | output | 1 | Three-wire clock output when an internal source drives the clock |
| di_i | input | 1 | Three-wire data input |
| do_o | output | 1 | Three-wire data output |
| scl_i | input | 1 | Two-wire clock line level |
| scl_drive_low | output | 1 | Pull the two-wire clock line low |
| sda_i | input | 1 | Two-wire data line level |
| sda_drive_low | output | 1 | Pull the two-wire data line low |
| irq_start | output | 1 | Start-condition interrupt |
| irq_ovf | output | 1 | Counter-overflow interrupt |

## Verification
A counter that is one step off moves the overflow by a full clock edge. That shows up at once as a wrong buffer byte and a wrong flag at the end of the transfer. It also changes the count read back mid-transfer in the preload test. A latch opened on the wrong phase makes do_o or SDA change one half-period early, so the first bit checked against the expected MSB sequence exposes it. A start or hold flag that does not set, or does not clear, is seen within a few cycles on scl_drive_low and on the interrupt pins.

// File: rtl/ussi_pkg.sv
package ussi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_3W  = 2'd1,
    MODE_2W  = 2'd2,
    MODE_RSV = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'd0,
    SRC_TIMER = 2'd1,
    SRC_SOFT  = 2'd2,
    SRC_RSV   = 2'd3
  } csrc_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_BUF  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;
endpackage

// File: rtl/ussi_sync.sv
module ussi_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= INIT;
        else     stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= INIT;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/ussi_clkgen.sv
module ussi_clkgen
  import ussi_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  csrc_e src,
  input  logic  pin_lvl,
  input  logic  tmr_evt,
  input  logic  sw_evt,
  output logic  edge_evt,
  output logic  new_lvl,
  output logic  level,
  output logic  int_clk
);
  logic pin_q;
  logic tick;
  logic int_src;

  assign int_src = (src == SRC_TIMER) || (src == SRC_SOFT);
  assign tick = (src == SRC_TIMER) ? tmr_evt :
                (src == SRC_SOFT)  ? sw_evt  : 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q   <= 1'b0;
      int_clk <= 1'b0;
    end else begin
      pin_q <= pin_lvl;
      if (en && int_src && tick) int_clk <= ~int_clk;
    end
  end

  assign edge_evt = en && ((src == SRC_PIN) ? (pin_lvl ^ pin_q) : tick);
  assign new_lvl  = (src == SRC_PIN) ? pin_lvl : ~int_clk;
  assign level    = (src == SRC_PIN) ? pin_lvl : int_clk;

  AST_INT_CLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(int_clk)) else $error("internal clock moved while off"); // R11
endmodule

// File: rtl/ussi_counter.sv
module ussi_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  assign wrap = inc && !clr && !load && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (load) cnt <= load_val;
    else if (inc)  cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr && !load) |=> cnt == W'($past(cnt) + 1'b1)) else $error("count step"); // R4
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt == '0) else $error("count clear"); // R7
endmodule

// File: rtl/ussi_shifter.sv
module ussi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sample,
  input  logic         din,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         latch_open,
  input  logic         capture,
  output logic [W-1:0] dr,
  output logic [W-1:0] buf_q,
  output logic         out_bit
);
  logic [W-1:0] dr_next;

  always_comb begin
    if (wr_en)       dr_next = wr_data;
    else if (sample) dr_next = {dr[W-2:0], din};
    else             dr_next = dr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dr      <= '0;
      buf_q   <= '0;
      out_bit <= 1'b1;
    end else begin
      dr <= dr_next;
      if (capture)    buf_q   <= dr_next;
      if (latch_open) out_bit <= dr[W-1];
    end
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_open |=> $stable(out_bit)) else $error("latch moved while closed"); // R3
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(buf_q)) else $error("buffer moved"); // R5
  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (rst)
    (sample && !wr_en) |=> (dr[0] == $past(din)) && (dr[W-1:1] == $past(dr[W-2:0])))
    else $error("shift"); // R2
endmodule

// File: rtl/ussi_top.sv
module ussi_top
  import ussi_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tmr_match,
  input  logic          sck_i,
  output logic          sck_o,
  input  logic          di_i,
  output logic          do_o,
  input  logic          scl_i,
  output logic          scl_drive_low,
  input  logic          sda_i,
  output logic          sda_drive_low,
  output logic          irq_start,
  output logic          irq_ovf
);
  localparam int PAD = DW - 2 - CW;

  mode_e mode;
  csrc_e src;
  logic  fall_sel, ie_start, ie_ovf;
  logic  start_flag, ovf_flag;

  logic [3:0] pins_s;
  logic sck_s, di_s, sda_s, scl_s, sda_q;

  ussi_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .INIT(4'b1100)) u_sync (
    .clk(clk), .rst(rst),
    .d({scl_i, sda_i, di_i, sck_i}),
    .q(pins_s)
  );
  assign {scl_s, sda_s, di_s, sck_s} = pins_s;

  logic en, two_w, int_src;
  logic ctrl_wr, stat_wr, data_wr, sw_evt;
  assign two_w   = (mode == MODE_2W);
  assign en      = (mode == MODE_3W) || two_w;
  assign int_src = (src == SRC_TIMER) || (src == SRC_SOFT);
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);
  assign data_wr = bus_wr && (bus_addr == A_DATA);
  assign sw_evt  = ctrl_wr && bus_wdata[5];

  logic raw_edge, new_lvl, level, int_clk;
  ussi_clkgen u_clkgen (
    .clk(clk), .rst(rst), .en(en), .src(src),
    .pin_lvl(two_w ? scl_s : sck_s),
    .tmr_evt(tmr_match), .sw_evt(sw_evt),
    .edge_evt(raw_edge), .new_lvl(new_lvl), .level(level), .int_clk(int_clk)
  );

  logic edge_ok, sample, latch_open, start_det;
  assign edge_ok    = raw_edge && !(two_w && start_flag);
  assign sample     = edge_ok && (new_lvl ^ fall_sel);
  assign latch_open = (level == fall_sel);
  assign start_det  = two_w && scl_s && sda_q && !sda_s;

  logic [CW-1:0] cnt;
  logic          wrap;
  ussi_counter #(.W(CW)) u_cnt (
    .clk(clk), .rst(rst), .clr(start_det), .load(stat_wr),
    .load_val(bus_wdata[CW-1:0]), .inc(edge_ok), .cnt(cnt), .wrap(wrap)
  );

  logic [DW-1:0] dr, buf_q;
  logic          out_bit;
  ussi_shifter #(.W(DW)) u_shift (
    .clk(clk), .rst(rst), .sample(sample), .din(two_w ? sda_s : di_s),
    .wr_en(data_wr), .wr_data(bus_wdata), .latch_open(latch_open),
    .capture(wrap), .dr(dr), .buf_q(buf_q), .out_bit(out_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_OFF;
      src      <= SRC_PIN;
      fall_sel <= 1'b0;
      ie_start <= 1'b0;
      ie_ovf   <= 1'b0;
      sda_q    <= 1'b1;
    end else begin
      sda_q <= sda_s;
      if (ctrl_wr) begin
        mode     <= mode_e'(bus_wdata[1:0]);
        src      <= csrc_e'(bus_wdata[3:2]);
        fall_sel <= bus_wdata[4];
        ie_start <= bus_wdata[6];
        ie_ovf   <= bus_wdata[7];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      if (start_det)                  start_flag <= 1'b1;
      else if (stat_wr && bus_wdata[7]) start_flag <= 1'b0;
      if (wrap)                       ovf_flag <= 1'b1;
      else if (stat_wr && bus_wdata[6]) ovf_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata     <= '0;
      do_o          <= 1'b0;
      sck_o         <= 1'b0;
      sda_drive_low <= 1'b0;
      scl_drive_low <= 1'b0;
      irq_start     <= 1'b0;
      irq_ovf       <= 1'b0;
    end else begin
      case (bus_addr)
        A_DATA:  bus_rdata <= dr;
        A_BUF:   bus_rdata <= buf_q;
        A_STAT:  bus_rdata <= {start_flag, ovf_flag, {PAD{1'b0}}, cnt};
        default: bus_rdata <= {ie_ovf, ie_start, 1'b0, fall_sel, src, mode};
      endcase
      do_o          <= (mode == MODE_3W) && out_bit;
      sck_o         <= (mode == MODE_3W) && int_src && int_clk;
      sda_drive_low <= two_w && !out_bit;
      scl_drive_low <= two_w && (start_flag || ovf_flag || (int_src && !int_clk));
      irq_start     <= start_flag && ie_start;
      irq_ovf       <= ovf_flag && ie_ovf;
    end
  end

  AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
    wrap |=> ovf_flag) else $error("overflow flag"); // R4
  AST_START_FLAG: assert property (@(posedge clk) disable iff (rst)
    start_det |=> start_flag) else $error("start flag"); // R7
  AST_HOLD_SCL: assert property (@(posedge clk) disable iff (rst)
    (two_w && (start_flag || ovf_flag)) |=> scl_drive_low) else $error("hold"); // R8
  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_OFF) |=> !do_o && !sck_o && !sda_drive_low && !scl_drive_low)
    else $error("off pins"); // R11
  AST_IRQ_OVF: assert property (@(posedge clk) disable iff (rst)
    irq_ovf |-> $past(ovf_flag && ie_ovf)) else $error("irq ovf"); // R10
endmodule

// File: tb/ussi_top_test.sv
module ussi_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] bus_addr = 2'd0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic tmr_match = 1'b0;
  logic sck_b = 1'b0, di_b = 1'b0, scl_b = 1'b1, sda_b = 1'b1;
  logic sck_o, do_o, scl_drive_low, sda_drive_low, irq_start, irq_ovf;
  logic scl_line, sda_line;

  int n_checks = 0;
  int n_fail = 0;
  logic done = 1'b0;

  assign scl_line = scl_b & ~scl_drive_low;
  assign sda_line = sda_b & ~sda_drive_low;

  always #4 clk = ~clk;

  ussi_top uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_match(tmr_match),
    .sck_i(sck_b), .sck_o(sck_o), .di_i(di_b), .do_o(do_o),
    .scl_i(scl_line), .scl_drive_low(scl_drive_low),
    .sda_i(sda_line), .sda_drive_low(sda_drive_low),
    .irq_start(irq_start), .irq_ovf(irq_ovf)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    wait_n(2);
    d = bus_rdata;
  endtask

  function automatic logic [7:0] shl(input logic [7:0] v, input logic b);
    return {v[6:0], b};
  endfunction

  // external clock, three-wire; fall=0 samples on rise, fall=1 samples on fall
  task automatic pin_byte(input logic fall, input logic [7:0] tx, input logic [7:0] rx,
                          output logic [7:0] seen);
    for (int k = 0; k < 8; k++) begin
      di_b = rx[7-k];
      if (!fall) begin
        wait_n(8); seen[7-k] = do_o;
        sck_b = 1'b1; wait_n(8); sck_b = 1'b0; wait_n(8);
      end else begin
        sck_b = 1'b1; wait_n(8); seen[7-k] = do_o;
        sck_b = 1'b0; wait_n(8);
      end
    end
  endtask

  task automatic int_event(input logic use_tmr);
    if (use_tmr) begin
      @(negedge clk); tmr_match = 1'b1; @(negedge clk); tmr_match = 1'b0;
    end else begin
      wr(2'd3, 8'h29);
    end
  endtask

  task automatic int_byte(input logic use_tmr, input logic [7:0] tx, input logic [7:0] rx);
    logic [7:0] seen, v;
    logic hi_ok;
    hi_ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      di_b = rx[7-k];
      wait_n(4); seen[7-k] = do_o;
      int_event(use_tmr); wait_n(4);
      if (sck_o !== 1'b1) hi_ok = 1'b0;
      int_event(use_tmr); wait_n(4);
    end
    chk("R6 internal clock high after odd event", {7'd0, hi_ok}, 8'd1);
    chk("R6 internal clock idles low", {7'd0, sck_o}, 8'd0);
    chk("R3 master MSB-first output", seen, tx);
    rd(2'd0, v); chk("R6 master received data", v, rx);
    rd(2'd1, v); chk("R5 master buffer", v, rx);
    rd(2'd2, v); chk("R4 master overflow status", v, 8'h40);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, tx, rx, seen, last_rx;
    void'($urandom(32'd7741));
    wait_n(4);
    rst = 1'b0;
    wait_n(2);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v); chk("R1 register reset", v, 8'h00);
    end
    chk("R1 pins reset", {2'b0, do_o, sck_o, sda_drive_low, scl_drive_low, irq_start, irq_ovf}, 8'h00);

    // R2 R3 R4 R5 R10: three-wire, rising sample, random bytes
    wr(2'd3, 8'h81);
    for (int t = 0; t < 4; t++) begin
      tx = 8'($urandom); rx = 8'($urandom);
      if (t == 0) begin tx = 8'h80; rx = 8'h01; end
      wr(2'd2, 8'hC0);
      wr(2'd0, tx);
      pin_byte(1'b0, tx, rx, seen);
      chk("R3 do_o MSB-first (rising sample)", seen, tx);
      chk("R10 irq_ovf with enable", {7'd0, irq_ovf}, 8'd1);
      rd(2'd0, v); chk("R2 received byte", v, rx);
      rd(2'd1, v); chk("R5 buffer copy", v, rx);
      rd(2'd2, v); chk("R4 overflow flag and count", v, 8'h40);
    end
    wr(2'd2, 8'h40); wait_n(3);
    rd(2'd2, v); chk("R9 overflow cleared by write 1", v, 8'h00);
    chk("R10 irq_ovf drops", {7'd0, irq_ovf}, 8'd0);

    // R2 falling-edge sample
    wr(2'd3, 8'h11);
    tx = 8'($urandom); rx = 8'($urandom);
    wr(2'd0, tx);
    pin_byte(1'b1, tx, rx, seen);
    chk("R3 do_o MSB-first (falling sample)", seen, tx);
    rd(2'd0, v); chk("R2 falling sample byte", v, rx);
    chk("R10 irq_ovf masked", {7'd0, irq_ovf}, 8'd0);

    // R6 software strobe and timer sources
    wr(2'd3, 8'h09); wr(2'd2, 8'hC0);
    tx = 8'($urandom); rx = 8'($urandom);
    wr(2'd0, tx); wait_n(3);
    int_byte(1'b0, tx, rx);
    wr(2'd3, 8'h05); wr(2'd2, 8'hC0);
    tx = 8'($urandom); rx = 8'($urandom); last_rx = rx;
    wr(2'd0, tx); wait_n(3);
    int_byte(1'b1, tx, rx);

    // R4 R5 R9 counter preload and wrap edge
    wr(2'd3, 8'h01);
    wr(2'd2, 8'hCE);
    rd(2'd2, v); chk("R9 counter load", v, 8'h0E);
    wr(2'd0, 8'hA5); di_b = 1'b0;
    sck_b = 1'b1; wait_n(8);
    rd(2'd2, v); chk("R4 count 15 no flag", v, 8'h0F);
    rd(2'd1, v); chk("R5 buffer unchanged before wrap", v, last_rx);
    sck_b = 1'b0; wait_n(8);
    rd(2'd2, v); chk("R4 wrap to 0 sets flag", v, 8'h40);
    rd(2'd1, v); chk("R5 buffer at wrap", v, shl(8'hA5, 1'b0));

    // R11 off mode
    wr(2'd3, 8'h00); wr(2'd2, 8'h40);
    wr(2'd0, 8'h3C);
    for (int i = 0; i < 3; i++) begin
      sck_b = 1'b1; wait_n(8); sck_b = 1'b0; wait_n(8);
    end
    rd(2'd2, v); chk("R11 no count when off", v, 8'h00);
    rd(2'd0, v); chk("R11 no shift when off", v, 8'h3C);
    chk("R11 pins released", {4'd0, do_o, sck_o, sda_drive_low, scl_drive_low}, 8'h00);
    wr(2'd0, 8'hFF); wait_n(4);

    // R7 no start detection in three-wire
    wr(2'd3, 8'h01); wr(2'd2, 8'h00);
    sda_b = 1'b0; wait_n(6); sda_b = 1'b1; wait_n(6);
    rd(2'd2, v); chk("R7 start ignored in three-wire", v & 8'h80, 8'h00);

    // R7 R8 R9 R10 two-wire start
    wr(2'd3, 8'h42); wait_n(4);
    chk("R3 SDA released for 1", {7'd0, sda_drive_low}, 8'd0);
    wr(2'd2, 8'h05);
    sda_b = 1'b0; wait_n(6);
    rd(2'd2, v); chk("R7 start flag and counter clear", v, 8'h80);
    chk("R10 irq_start", {7'd0, irq_start}, 8'd1);
    chk("R8 clock held after start", {7'd0, scl_drive_low}, 8'd1);
    wr(2'd2, 8'h00);
    rd(2'd2, v); chk("R9 write 0 keeps start flag", v, 8'h80);
    scl_b = 1'b0; wait_n(4); sda_b = 1'b1;
    wr(2'd2, 8'h80); wait_n(4);
    rd(2'd2, v); chk("R9 start cleared", v, 8'h00);
    chk("R8 clock released", {7'd0, scl_drive_low}, 8'd0);

    // R2 R8 two-wire receive then hold
    rx = 8'($urandom);
    for (int k = 0; k < 8; k++) begin
      sda_b = rx[7-k]; wait_n(8);
      scl_b = 1'b1; wait_n(8); scl_b = 1'b0; wait_n(8);
    end
    sda_b = 1'b1;
    rd(2'd0, v); chk("R2 two-wire received byte", v, rx);
    chk("R8 clock held after overflow", {7'd0, scl_drive_low}, 8'd1);
    chk("R3 SDA follows latched MSB", {7'd0, sda_drive_low}, {7'd0, ~rx[7]});
    scl_b = 1'b1; wait_n(8);
    rd(2'd2, v); chk("R8 remote edges blocked while held", v, 8'h40);
    scl_b = 1'b0; wait_n(4);
    wr(2'd2, 8'h40); wait_n(4);
    chk("R8 release after overflow clear", {7'd0, scl_drive_low}, 8'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule